// File: doc/BRIEF.md
# Converter Bus Slave Interface

This block is the two-wire serial slave front end of a small data-acquisition device that has four analog inputs and one analog output, each 8 bits. It oversamples the bus clock and data lines on a fast system clock and recognises start and stop conditions. It compares the received address with a 7-bit identity: a fixed upper part plus three strap pins, so up to eight such devices can share one bus. The data line is open drain, so the block drives it only through an active-high pull-low enable.

In a write transfer the block routes the data bytes by their position. The first byte after the address goes to the control register. Every later byte goes to the DAC data register, and each DAC write is announced by a one-cycle valid pulse. In a read transfer the block shifts out the most recent converter result, MSB first. At the falling clock edge that ends each acknowledge, it sends a one-cycle trigger to a separate conversion controller. The value returned for that trigger is the byte sent on the next read slot.

The result input is a valid-only stream, and the block never applies back-pressure. Each `res_valid` beat overwrites the held result at once. The conversion controller therefore has to deliver its beat before the next byte slot opens, which is at least nine bus clock periods after the trigger.

Top module: `acq_bus_slave`

## Requirements
- R1: After reset `ctrl_q` and `dac_q` are 0x00, `sda_pull` and `conv_start` are low, and the first byte read before any result beat is 0x80.
- R2: An address byte whose upper seven bits equal {4'b1001, `addr_pins`} is acknowledged; its bit 0 selects the direction, 1 = read and 0 = write.
- R3: An address byte that does not match is not acknowledged, and every byte up to the next start condition leaves `ctrl_q` and `dac_q` unchanged and raises no `dac_valid`.
- R4: In a write transfer the first data byte after the address is stored in `ctrl_q`.
- R5: Every data byte after the control byte in the same write transfer is stored in `dac_q`, with `dac_valid` high for exactly the one cycle in which the new value first appears.
- R6: After each byte it accepts, the block holds `sda_pull` high across the whole high phase of the ninth clock; `sda_pull` never changes while the synchronised SCL stays high.
- R7: In a read transfer, bytes go out MSB first. The first byte is the result held when the address is acknowledged. `conv_start` pulses for one cycle at the falling edge that ends the address acknowledge and at the falling edge that ends each acknowledge from the master, and the result of each trigger is the next byte read.
- R8: When the master does not acknowledge a read byte, the block releases SDA, raises no `conv_start`, and stays silent until the next start condition.
- R9: A stop or a repeated start ends a write transfer, and the next write transfer again stores its first data byte in `ctrl_q`.
- R10: A `res_valid` beat replaces the held result with `res_data`; results that are never read are overwritten without notice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull the data line low, 0 = release |
| addr_pins | input | 3 | Strapped low address bits |
| ctrl_q | output | 8 | Control register |
| dac_q | output | 8 | DAC data register |
| dac_valid | output | 1 | One-cycle pulse marking a new `dac_q` |
| conv_start | output | 1 | One-cycle conversion trigger |
| res_valid | input | 1 | Conversion result beat valid |
| res_data | input | 8 | Conversion result byte |

## Verification
The assertions assume a legal bus: SDA changes only while SCL is low, except at start and stop conditions. They also assume the master never signals a start or stop while the slave is pulling SDA low. The bench master moves SDA a quarter bit period after each SCL fall and raises SCL only after that. It issues start and stop only while the slave has released the line. Each quarter period lasts ten system clocks, so the synchroniser latency is always well inside one bus phase. The converter model returns its beat twenty cycles after each trigger, which is long before the next byte slot.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ACK_RX = 3'd2,
    ST_RX     = 3'd3,
    ST_TX     = 3'd4,
    ST_ACK_TX = 3'd5
  } fsm_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // the bus idles high, so every stage resets to 1
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/bus_events.sv
module bus_events #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic sda_rise, sda_fall;

  line_sync #(.STAGES(STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .q(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  line_sync #(.STAGES(STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .q(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  // data edges while the clock is high are bus conditions
  assign start_det = scl_s & sda_fall;
  assign stop_det  = scl_s & sda_rise;
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import acq_pkg::*;
#(
  parameter int                     PIN_W     = 3,
  parameter logic [ADDR_W-PIN_W-1:0] FIXED_HI = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ctrl_we,
  output logic              dac_we,
  output logic              conv_start,
  output logic              sda_pull,
  output logic [2:0]        state_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  fsm_e              state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              is_read, first_data, m_ack;
  logic [ADDR_W-1:0] my_addr;

  assign my_addr = {FIXED_HI, addr_pins};
  assign rx_byte = rx_sh;
  assign state_o = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_read    <= 1'b0;
      first_data <= 1'b0;
      m_ack      <= 1'b0;
      ctrl_we    <= 1'b0;
      dac_we     <= 1'b0;
      conv_start <= 1'b0;
      sda_pull   <= 1'b0;
    end else begin
      ctrl_we    <= 1'b0;
      dac_we     <= 1'b0;
      conv_start <= 1'b0;
      if (start_det) begin
        state      <= ST_ADDR;
        bitcnt     <= '0;
        first_data <= 1'b1;
        sda_pull   <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == my_addr) begin
                  is_read  <= rx_sh[0];
                  sda_pull <= 1'b1;
                  state    <= ST_ACK_RX;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                ctrl_we    <= first_data;
                dac_we     <= ~first_data;
                first_data <= 1'b0;
                sda_pull   <= 1'b1;
                state      <= ST_ACK_RX;
              end
            end
          end
          ST_ACK_RX: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                tx_sh      <= tx_byte;
                sda_pull   <= ~tx_byte[BYTE_W-1];
                conv_start <= 1'b1;
                state      <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                state    <= ST_ACK_TX;
              end else begin
                tx_sh    <= tx_sh << 1;
                sda_pull <= ~tx_sh[BYTE_W-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          ST_ACK_TX: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh      <= tx_byte;
                sda_pull   <= ~tx_byte[BYTE_W-1];
                conv_start <= 1'b1;
                state      <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acq_bus_slave.sv
module acq_bus_slave
  import acq_pkg::*;
#(
  parameter int                      SYNC_STAGES = 2,
  parameter int                      PIN_W       = 3,
  parameter logic [ADDR_W-PIN_W-1:0] FIXED_HI    = 4'b1001,
  parameter logic [BYTE_W-1:0]       RESULT_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  input  logic [PIN_W-1:0]  addr_pins,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] dac_q,
  output logic              dac_valid,
  output logic              conv_start,
  input  logic              res_valid,
  input  logic [BYTE_W-1:0] res_data
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte, result_q;
  logic              ctrl_we, dac_we;
  logic [2:0]        fsm_state;

  bus_events #(.STAGES(SYNC_STAGES)) u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  xfer_fsm #(.PIN_W(PIN_W), .FIXED_HI(FIXED_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .addr_pins(addr_pins), .tx_byte(result_q), .rx_byte(rx_byte),
    .ctrl_we(ctrl_we), .dac_we(dac_we), .conv_start(conv_start),
    .sda_pull(sda_pull), .state_o(fsm_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dac_q     <= '0;
      dac_valid <= 1'b0;
      result_q  <= RESULT_INIT;
    end else begin
      if (ctrl_we)   ctrl_q   <= rx_byte;
      if (dac_we)    dac_q    <= rx_byte;
      dac_valid <= dac_we;
      if (res_valid) result_q <= res_data;
    end
  end
endmodule

// File: rtl/acq_bus_slave_chk.sv
module acq_bus_slave_chk
  import acq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull,
  input logic       conv_start,
  input logic       dac_valid,
  input logic [2:0] fsm_state
);
  // R6
  pull_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));

  // R7
  conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  dac_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 3'(ST_IDLE)) |-> !sda_pull);

  // R7
  conv_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !scl_s);
endmodule

bind acq_bus_slave acq_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
  .conv_start(conv_start), .dac_valid(dac_valid), .fsm_state(fsm_state)
);

// File: tb/test_acq_bus_slave.sv
module test_acq_bus_slave;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] addr_pins = 3'b010;
  logic       res_valid = 1'b0;
  logic [7:0] res_data = 8'h00;
  logic       sda_pull, dac_valid, conv_start;
  logic [7:0] ctrl_q, dac_q;
  wire        sda_line = m_sda & ~sda_pull;

  int checks = 0, fails = 0, conv_cnt = 0, pend = 0;
  logic [7:0] dac_exp_q[$];

  always #4 clk = ~clk;

  acq_bus_slave i_acq_bus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .addr_pins(addr_pins), .ctrl_q(ctrl_q), .dac_q(dac_q),
    .dac_valid(dac_valid), .conv_start(conv_start),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [7:0] conv_val(int k);
    return 8'h21 + 8'(8'h11 * (k - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // converter model: answers each trigger 20 cycles later
  always @(negedge clk) begin
    res_valid <= 1'b0;
    if (conv_start) begin
      conv_cnt <= conv_cnt + 1;
      pend <= 20;
      res_data <= conv_val(conv_cnt + 1);
    end else if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) res_valid <= 1'b1;
    end
  end

  // scoreboard monitor for the DAC stream (R5)
  always @(negedge clk) begin
    if (rst_n && dac_valid) begin
      if (dac_exp_q.size() == 0) chk(1'b0, "R5 unexpected dac_valid", dac_q, 0);
      else begin
        logic [7:0] e;
        e = dac_exp_q.pop_front();
        chk(dac_q == e, "R5 dac_q on dac_valid", dac_q, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack_low);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack_low = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] p, input logic rd);
    return {4'b1001, p, rd};
  endfunction

  initial begin : wdog
    tick(150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(ctrl_q == 8'h00, "R1 ctrl_q reset", ctrl_q, 0);
    chk(dac_q == 8'h00, "R1 dac_q reset", dac_q, 0);
    chk(sda_pull == 1'b0 && conv_start == 1'b0, "R1 outputs low", sda_pull, 0);

    // R2 R4 R5 write: control then two DAC bytes
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    chk(a, "R2 write address acked", a, 1);
    wr_byte(8'h45, a);
    chk(a, "R6 control byte acked", a, 1);
    chk(ctrl_q == 8'h45, "R4 control register", ctrl_q, 8'h45);
    dac_exp_q.push_back(8'h9A);
    wr_byte(8'h9A, a);
    dac_exp_q.push_back(8'h3C);
    wr_byte(8'h3C, a);
    bus_stop();
    tick(Q);
    chk(dac_q == 8'h3C, "R5 last DAC byte kept", dac_q, 8'h3C);
    chk(ctrl_q == 8'h45, "R5 control untouched by DAC bytes", ctrl_q, 8'h45);

    // R3 mismatched address
    bus_start();
    wr_byte(addr_byte(3'b011, 1'b0), a);
    chk(!a, "R3 foreign address not acked", a, 0);
    wr_byte(8'h11, a);
    chk(!a, "R3 data after mismatch not acked", a, 0);
    wr_byte(8'h22, a);
    bus_stop();
    tick(Q);
    chk(ctrl_q == 8'h45, "R3 ctrl_q unchanged", ctrl_q, 8'h45);
    chk(dac_q == 8'h3C, "R3 dac_q unchanged", dac_q, 8'h3C);

    // R7 R10 read: 0x80 first, then converter results
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b1), a);
    chk(a, "R2 read address acked", a, 1);
    rd_byte(1'b1, d);
    chk(d == 8'h80, "R1 first read byte", d, 8'h80);
    rd_byte(1'b1, d);
    chk(d == conv_val(1), "R7 second read byte", d, conv_val(1));
    rd_byte(1'b0, d);
    chk(d == conv_val(2), "R10 third read byte", d, conv_val(2));
    tick(3 * Q);
    chk(conv_cnt == 3, "R8 no trigger after NACK", conv_cnt, 3);
    chk(sda_pull == 1'b0, "R8 SDA released after NACK", sda_pull, 0);
    bus_stop();

    // R7 next read returns the last triggered result
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b1), a);
    rd_byte(1'b0, d);
    chk(d == conv_val(3), "R7 result carried to next read", d, conv_val(3));
    bus_stop();
    tick(Q);
    chk(conv_cnt == 4, "R7 trigger count", conv_cnt, 4);

    // R9 repeated start restarts byte position
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    wr_byte(8'h5A, a);
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    wr_byte(8'h66, a);
    chk(ctrl_q == 8'h66, "R9 repeated start: first byte to control", ctrl_q, 8'h66);
    chk(dac_q == 8'h3C, "R9 repeated start: DAC untouched", dac_q, 8'h3C);
    bus_stop();

    // R9 stop then new write
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    wr_byte(8'h01, a);
    bus_stop();
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    wr_byte(8'h77, a);
    bus_stop();
    tick(Q);
    chk(ctrl_q == 8'h77, "R9 stop: first byte to control", ctrl_q, 8'h77);

    // R2 strap pins select the address
    addr_pins = 3'b101;
    tick(Q);
    bus_start();
    wr_byte(addr_byte(3'b101, 1'b0), a);
    chk(a, "R2 new strap address acked", a, 1);
    bus_stop();
    bus_start();
    wr_byte(addr_byte(3'b010, 1'b0), a);
    chk(!a, "R3 old strap address rejected", a, 0);
    bus_stop();
    tick(Q);
    chk(dac_exp_q.size() == 0, "R5 all DAC writes seen", dac_exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule